// File: doc/BRIEF.md
# Interrupt-Driven Key Matrix Scanner

This block finds a pressed key in a switch matrix without processor effort. Two cascaded down-counters step through every crossing of the matrix, one position per horizontal scan pulse. The low counter picks which drive line is pulled low. The high counter picks which return line is sampled. When the sampled line reads low, the counters stop where they are and an interrupt is raised. The stopped count is the keycode.

The interrupt routine reads one fixed address. During that read the block drives the keycode onto the data bus. When the read ends, the interrupt clears and scanning starts again. After a restart, the counters step off the reported position before the matrix is sampled again. A key that is still held therefore comes back only after one complete frame of the matrix.

The scan pulse comes from another clock domain and is synchronized inside the block. The tri-state bus is modelled as a data vector plus an output enable.

Top module: `kbd_scan_ctl`

## Requirements
- R1: After reset the column counter and the row counter are both 7. So `drive_n` is 8'h7F (bit 7 low), `irq` is 0, `bus_oe` is 0 and `bus_dout` is 0.
- R2: Each rising edge of `hsync_in`, after a two-flop synchronizer, decrements the column counter by one, with wrap from 0 to 7. A high level of any length counts once. `drive_n` has exactly the bit selected by the column counter low.
- R3: The row counter decrements, with wrap from 0 to 7, only on the step where the column counter wraps from 0 to 7. It therefore changes once every 8 scan pulses.
- R4: When `sense_n[row]` is low while scanning is armed, `irq` goes high on the next clock. Both counters then hold, and further scan pulses have no effect until the read ends.
- R5: A read strobe is `cpu_rd` high with `cpu_addr` equal to 16'hFFE0. While the strobe is active, `bus_oe` is 1 and `bus_dout` is {2'b00, row[2:0], column[2:0]}, with the row in bits 5:3 and the column in bits 2:0.
- R6: A read at any other address leaves `bus_oe` at 0 and `bus_dout` at 0, and leaves `irq` unchanged.
- R7: One clock after the read strobe ends, `irq` is 0 and scan pulses advance the counters again.
- R8: After a read ends, the matrix is not sampled until the first scan pulse has moved the counters. A key that is still held is reported again after exactly 64 further scan pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Asynchronous horizontal scan pulse |
| sense_n | input | 8 | Matrix return lines, low for a closed key on the driven line |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Processor read cycle |
| drive_n | output | 8 | Matrix drive lines, one low at a time |
| irq | output | 1 | Key-found interrupt, active high |
| bus_dout | output | 8 | Keycode onto the data bus |
| bus_oe | output | 1 | Data bus drive enable |

## Verification
The hardest case to reach is the re-report of a key that stays held across a read. Reaching it takes a frozen scan, a completed read and then a full 64-pulse frame with nothing else reporting. The bench models the matrix as a real crossing: the chosen return line follows the chosen drive line. It then counts scan pulses from reset to the first interrupt, and from the end of the read to the next interrupt. A key placed at the reset position (7,7) exercises the skip-after-resume rule. Without that rule the key would fire again at once.

// File: rtl/kbd_scan_ctl.sv
module kbd_scan_ctl #(
  parameter int          COL_BITS = 3,
  parameter int          ROW_BITS = 3,
  parameter int          BUS_W    = 8,
  parameter logic [15:0] KEY_ADDR = 16'hFFE0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hsync_in,
  input  logic [(1<<ROW_BITS)-1:0]  sense_n,
  input  logic [15:0]               cpu_addr,
  input  logic                      cpu_rd,
  output logic [(1<<COL_BITS)-1:0]  drive_n,
  output logic                      irq,
  output logic [BUS_W-1:0]          bus_dout,
  output logic                      bus_oe
);
  localparam int NCOL = 1 << COL_BITS;
  localparam int CODE_W = COL_BITS + ROW_BITS;
  localparam logic [COL_BITS-1:0] COL_TOP = '1;
  localparam logic [ROW_BITS-1:0] ROW_TOP = '1;

  logic [2:0]          hs_sync;
  logic [COL_BITS-1:0] col;
  logic [ROW_BITS-1:0] row;
  logic                frozen, skip, rd_q;

  wire step   = hs_sync[1] & ~hs_sync[2];
  wire adv    = step & ~frozen;
  wire rd_now = cpu_rd & (cpu_addr == KEY_ADDR);
  wire rd_end = rd_q & ~rd_now;
  wire hit    = ~frozen & ~skip & ~sense_n[row];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_sync <= '0;
      rd_q    <= 1'b0;
    end else begin
      hs_sync <= {hs_sync[1:0], hsync_in};
      rd_q    <= rd_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= COL_TOP;
      row <= ROW_TOP;
    end else if (adv) begin
      col <= col - 1'b1;
      if (col == '0) row <= row - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen <= 1'b0;
      skip   <= 1'b0;
    end else if (rd_end) begin
      frozen <= 1'b0;
      skip   <= 1'b1;
    end else begin
      if (hit) frozen <= 1'b1;
      if (adv) skip <= 1'b0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCOL; g++) begin : g_drv
      assign drive_n[g] = (col != COL_BITS'(g));
    end
  endgenerate

  assign irq      = frozen;
  assign bus_oe   = rd_now;
  assign bus_dout = rd_now ? BUS_W'({row, col}) : '0;

  p_col_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> col == $past(col) - 1'b1);
  p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && col != '0) |=> $stable(row));
  p_hit_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !skip && !sense_n[row] && !rd_end) |=> irq);
  p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_end) |=> ($stable(col) && $stable(row)));
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> bus_dout[BUS_W-1:CODE_W] == '0);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_end |=> !irq);
endmodule

// File: tb/kbd_scan_ctl_test.sv
module kbd_scan_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, hsync_in = 0, cpu_rd = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  sense_n, drive_n, bus_dout;
  logic        irq, bus_oe;
  logic        key_on = 0;
  logic [2:0]  kx = 0, ky = 0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    sense_n = '1;
    if (key_on) sense_n[ky] = drive_n[kx];
  end

  kbd_scan_ctl uut (.clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .sense_n(sense_n),
    .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .drive_n(drive_n), .irq(irq),
    .bus_dout(bus_dout), .bus_oe(bus_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; hsync_in = 0; cpu_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse(input int hi = 4);
    hsync_in = 1;
    repeat (hi) @(negedge clk);
    hsync_in = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulses_to_irq(output int n);
    n = 0;
    while (!irq && n < 100) begin pulse(); n++; end
  endtask

  task automatic read_code(input logic [15:0] a, output int code, output int oe);
    cpu_addr = a; cpu_rd = 1;
    @(negedge clk);
    code = bus_dout; oe = bus_oe;
    cpu_rd = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(drive_n == 8'h7F, "R1 drive", drive_n, 8'h7F);
    chk(!irq, "R1 irq", irq, 0);
    chk(!bus_oe && bus_dout == 0, "R1 bus", bus_oe, 0);
  endtask

  task automatic t_scan();
    int code, oe;
    do_reset();
    pulse();
    chk(drive_n == 8'hBF, "R2 one step", drive_n, 8'hBF);
    pulse(20);
    chk(drive_n == 8'hDF, "R2 long high counts once", drive_n, 8'hDF);
    repeat (6) pulse();
    read_code(16'hFFE0, code, oe);
    chk(code == 55, "R3 row step after wrap", code, 55);
    chk(oe == 1, "R5 oe", oe, 1);
  endtask

  task automatic t_find();
    int n, code, oe;
    kx = 2; ky = 5; key_on = 1;
    do_reset();
    pulses_to_irq(n);
    chk(n == 21, "R4 pulses to find", n, 21);
    chk(irq, "R4 irq", irq, 1);
    repeat (3) pulse();
    chk(drive_n == 8'hFB, "R4 frozen drive", drive_n, 8'hFB);
    read_code(16'hFFE1, code, oe);
    chk(oe == 0 && code == 0, "R6 wrong addr oe", oe, 0);
    chk(irq, "R6 irq kept", irq, 1);
    cpu_addr = 16'hFFE0; cpu_rd = 1;
    @(negedge clk);
    chk(bus_dout == 42, "R5 keycode", bus_dout, 42);
    chk(irq, "R5 irq during read", irq, 1);
    cpu_rd = 0;
    @(negedge clk);
    chk(!irq, "R7 irq released", irq, 0);
    pulse();
    chk(drive_n == 8'hFD, "R7 scan resumes", drive_n, 8'hFD);
    key_on = 0;
  endtask

  task automatic t_rereport();
    int n, code, oe;
    kx = 7; ky = 7; key_on = 1;
    do_reset();
    chk(irq, "R4 hit at reset position", irq, 1);
    read_code(16'hFFE0, code, oe);
    chk(code == 63, "R5 keycode 63", code, 63);
    repeat (3) @(negedge clk);
    chk(!irq, "R8 no immediate refire", irq, 0);
    pulses_to_irq(n);
    chk(n == 64, "R8 full frame", n, 64);
    key_on = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_scan();
        t_find();
        t_rereport();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule